// File: doc/BRIEF.md
# Daisy-Chain Command Frame Transmitter

This block turns one register-write request for a chain of stacked battery-monitor devices into a 32-bit command word and sends it over a serial link. A request is made of a 5-bit chain position, a 6-bit register number, an 8-bit payload and a broadcast flag. The chain position is bit-reversed before it is placed in the address field, because the devices take their address least significant bit first. An 8-bit check code over the 21-bit header-and-payload field protects the word. A fixed trailer closes it.

A second request kind, selected with `dummy_i`, sends the filler word that a host must clock out while it reads data back from the chain. That word addresses position 0x1F with the broadcast flag clear and carries a valid check code. The word is shifted out most significant bit first in SPI mode 1. The clock idles low, data changes on the rising edge and the far end samples on the falling edge. The serial clock is derived from the system clock by a parameterised divider. After the chip select returns high, a one-cycle completion pulse is given.

Top module: `cmd_frame_tx`

## Requirements
- R1: For a normal request the word is: address field in bits 31:27, register number in bits 26:21, payload in bits 20:13, broadcast flag in bit 12, bit 11 zero, check code in bits 10:3, and bits 2:0 equal to 3'b010.
- R2: The check code uses polynomial 0x2F. Let V be the 24-bit value {3'b000, word[31:11]}. A byte table entry E(n) is n shifted left eight times, XORed with 0x2F each time a one is shifted out. The code is c1 = E(V[23:16]), then c2 = E(c1 ^ V[15:8]), and the result is c2 ^ V[7:0]. Position 0x1F with register 0, payload 0 and the flag clear gives code 0x61.
- R3: The address field is the chain position with its bit order reversed: word bit 31 carries position bit 0 and word bit 27 carries position bit 4.
- R4: A request with `dummy_i` high sends 32'hF800030A whatever the other request inputs hold.
- R5: In SPI mode 1 the serial clock is low whenever `cs_n_o` is high. The word goes out MSB first on `mosi_o`, one bit for each falling edge, with exactly 32 rising edges per word. While `cs_n_o` is low, `mosi_o` changes only on a rising edge.
- R6: Each serial clock half period lasts HALF_DIV system cycles, and `cs_n_o` stays low for exactly 64*HALF_DIV system cycles per word (32 serial clock periods).
- R7: A start request made while a word is in flight is ignored: the word in flight is not altered and no further word follows it.
- R8: `done_o` is high for exactly one cycle, in the first cycle that `cs_n_o` is high after a word. A start request made in that same cycle is accepted.
- R9: During and after reset, `cs_n_o` is high and `sclk_o`, `mosi_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe; taken only when idle |
| dummy_i | input | 1 | Send the readback filler word instead of a command |
| dev_idx_i | input | 5 | Chain position of the target device (0 is the first device) |
| reg_addr_i | input | 6 | Register number inside the device |
| data_i | input | 8 | Payload byte |
| all_i | input | 1 | Broadcast flag: the command applies to every device |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the chain |
| cs_n_o | output | 1 | Active-low chip select |
| done_o | output | 1 | One-cycle pulse after a word completes |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. The idle state is entered on the edge that raises `done_o`, so a start held in that cycle must begin the next word at once. The bench provokes this by raising `start_i` in the exact cycle it sees `done_o` high. It then judges that chip select drops on the next edge, that the pulse has cleared, and that the second word arrives whole with its own fields. In the opposite case, a start arriving mid-word with different fields, the bench checks that the word in flight is unchanged and that the link stays idle afterwards.

// File: rtl/cft_pkg.sv
// Package: shared constants and the check-code table step for the
// command frame transmitter. Assumes a 32-bit frame of fixed layout.
package cft_pkg;
    localparam int DEV_W   = 5;
    localparam int REG_W   = 6;
    localparam int DAT_W   = 8;
    localparam int CRC_W   = 8;
    localparam int FIELD_W = DEV_W + REG_W + DAT_W + 1;      // 20 bits of header+payload
    localparam int CODE_IN_W = FIELD_W + 1;                  // plus the spare bit 11 -> 21
    localparam int FRAME_W = CODE_IN_W + CRC_W + 3;          // 32
    localparam logic [CRC_W-1:0] CRC_POLY   = 8'h2F;
    localparam logic [2:0]       TRAILER    = 3'b010;
    localparam logic [DEV_W-1:0] FILLER_DEV = 5'h1F;

    // One table entry: eight left shifts with conditional polynomial XOR.
    function automatic logic [CRC_W-1:0] crc_entry(input logic [CRC_W-1:0] n);
        logic [CRC_W-1:0] r;
        logic             top;
        r = n;
        for (int i = 0; i < CRC_W; i++) begin
            top = r[CRC_W-1];
            r   = {r[CRC_W-2:0], 1'b0};
            if (top) r = r ^ CRC_POLY;
        end
        return r;
    endfunction
endpackage

// File: rtl/cft_crc8.sv
// Check-code generator: two table steps over the upper bytes of the
// zero-extended 24-bit field, then a plain XOR with the lowest byte.
// Purely combinational; assumes the field is header bits 31:11.
module cft_crc8
    import cft_pkg::*;
(
    input  logic [CODE_IN_W-1:0] field_i,
    output logic [CRC_W-1:0]     crc_o
);
    localparam int V_W = 3 * CRC_W;

    logic [V_W-1:0]   v;
    logic [CRC_W-1:0] stage1;
    logic [CRC_W-1:0] stage2;

    // Two chained table look-ups and the final byte XOR.
    always_comb begin
        v      = {{(V_W-CODE_IN_W){1'b0}}, field_i};
        stage1 = crc_entry(v[V_W-1 -: CRC_W]);
        stage2 = crc_entry(stage1 ^ v[2*CRC_W-1 -: CRC_W]);
        crc_o  = stage2 ^ v[CRC_W-1:0];
    end
endmodule

// File: rtl/cft_builder.sv
// Word builder: reverses the chain position into the address field,
// substitutes the readback filler fields when asked, appends the check
// code and trailer. Combinational; the shifter latches the result.
module cft_builder
    import cft_pkg::*;
(
    input  logic               dummy_i,
    input  logic [DEV_W-1:0]   dev_idx_i,
    input  logic [REG_W-1:0]   reg_addr_i,
    input  logic [DAT_W-1:0]   data_i,
    input  logic               all_i,
    output logic [FRAME_W-1:0] word_o
);
    logic [DEV_W-1:0]     dev_rev;
    logic [DEV_W-1:0]     dev_fld;
    logic [REG_W-1:0]     reg_fld;
    logic [DAT_W-1:0]     dat_fld;
    logic                 all_fld;
    logic [CODE_IN_W-1:0] code_in;
    logic [CRC_W-1:0]     code;

    // Bit reversal of the chain position (sent LSB first on the wire).
    for (genvar g = 0; g < DEV_W; g++) begin : g_rev
        assign dev_rev[g] = dev_idx_i[DEV_W-1-g];
    end

    // Field selection: filler word or the caller's request.
    always_comb begin
        if (dummy_i) begin
            dev_fld = FILLER_DEV;
            reg_fld = '0;
            dat_fld = '0;
            all_fld = 1'b0;
        end else begin
            dev_fld = dev_rev;
            reg_fld = reg_addr_i;
            dat_fld = data_i;
            all_fld = all_i;
        end
    end

    assign code_in = {dev_fld, reg_fld, dat_fld, all_fld, 1'b0};

    cft_crc8 u_crc (
        .field_i (code_in),
        .crc_o   (code)
    );

    assign word_o = {code_in, code, TRAILER};
endmodule

// File: rtl/cft_shifter.sv
// Mode-1 serial shifter: latches a word when idle, toggles the serial
// clock every HALF_DIV cycles, advances the data on rising edges after
// the first and releases chip select on the 32nd falling edge.
// Assumes HALF_DIV >= 1; start requests while busy are dropped.
module cft_shifter #(
    parameter int HALF_DIV = 3,
    parameter int WORD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              cs_n_o,
    output logic              done_o
);
    localparam int PH_W  = $clog2(HALF_DIV + 1);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(HALF_DIV - 1);
    localparam logic [PH_W-1:0]  PH_ONE   = PH_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    logic              busy_q;
    logic              sclk_q;
    logic              done_q;
    logic [PH_W-1:0]   ph_q;
    logic [CNT_W-1:0]  rise_q;
    logic [WORD_W-1:0] sh_q;

    // Sequencer: load, divide, shift on rise, finish on last fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
            ph_q   <= '0;
            rise_q <= '0;
            sh_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (load_i) begin
                    busy_q <= 1'b1;
                    sh_q   <= word_i;
                    ph_q   <= '0;
                    rise_q <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (ph_q == PH_LAST) begin
                ph_q   <= '0;
                sclk_q <= ~sclk_q;
                if (!sclk_q) begin
                    if (rise_q != '0) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
                    rise_q <= rise_q + CNT_ONE;
                end else if (rise_q == CNT_FULL) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else begin
                ph_q <= ph_q + PH_ONE;
            end
        end
    end

    assign sclk_o = sclk_q;
    assign mosi_o = busy_q & sh_q[WORD_W-1];
    assign cs_n_o = ~busy_q;
    assign done_o = done_q;

    // R5: clock parked low outside a word.
    assert_sclk_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R5: inside a word, data moves only together with a rising clock.
    assert_mosi_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && $past(!cs_n_o) && !$stable(mosi_o)) |-> $rose(sclk_o));

    // R6: never more rising edges than bits in a word.
    assert_rise_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q <= CNT_FULL);

    // R7: the latched word moves only on a rising clock while busy.
    assert_word_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && !$rose(sclk_q)) |-> $stable(sh_q));

    // R8: completion pulse lasts one cycle.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: completion pulse coincides with chip select rising.
    assert_done_on_cs_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(cs_n_o));
endmodule

// File: rtl/cmd_frame_tx.sv
// Top: command frame transmitter for a daisy chain of monitor devices.
// Builds the 32-bit word from the request inputs and hands it to the
// mode-1 shifter. Request inputs are sampled only in the accepting cycle.
module cmd_frame_tx
    import cft_pkg::*;
#(
    parameter int HALF_DIV = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dummy_i,
    input  logic [DEV_W-1:0] dev_idx_i,
    input  logic [REG_W-1:0] reg_addr_i,
    input  logic [DAT_W-1:0] data_i,
    input  logic             all_i,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             cs_n_o,
    output logic             done_o
);
    logic [FRAME_W-1:0] word;

    cft_builder u_build (
        .dummy_i    (dummy_i),
        .dev_idx_i  (dev_idx_i),
        .reg_addr_i (reg_addr_i),
        .data_i     (data_i),
        .all_i      (all_i),
        .word_o     (word)
    );

    cft_shifter #(.HALF_DIV(HALF_DIV), .WORD_W(FRAME_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start_i),
        .word_i (word),
        .sclk_o (sclk_o),
        .mosi_o (mosi_o),
        .cs_n_o (cs_n_o),
        .done_o (done_o)
    );

    // R9: outputs at rest right after reset.
    assert_reset_rest_R9: assert property (@(posedge clk)
        !rst_n |=> (cs_n_o && !sclk_o && !mosi_o && !done_o));
endmodule

// File: tb/sim_cmd_frame_tx.sv
module sim_cmd_frame_tx;
    localparam int H = 3;
    localparam int NV = 8;
    // {dummy, dev_idx, reg_addr, data, all}
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 5'd0,  6'h0D, 8'h00, 1'b1},
        {1'b0, 5'd1,  6'h1C, 8'h34, 1'b0},
        {1'b0, 5'd3,  6'h14, 8'hA5, 1'b0},
        {1'b0, 5'd7,  6'h15, 8'hF8, 1'b1},
        {1'b0, 5'd31, 6'h3F, 8'hFF, 1'b1},
        {1'b1, 5'd9,  6'h22, 8'h5A, 1'b1},
        {1'b0, 5'd16, 6'h01, 8'h80, 1'b0},
        {1'b0, 5'd10, 6'h2A, 8'h55, 1'b1}
    };

    logic clk = 0, rst_n = 0, start = 0, dummy = 0, all_f = 0;
    logic [4:0] idx = 0;
    logic [5:0] rg = 0;
    logic [7:0] dat = 0;
    logic sclk, mosi, cs_n, done;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    cmd_frame_tx #(.HALF_DIV(H)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dummy_i(dummy),
        .dev_idx_i(idx), .reg_addr_i(rg), .data_i(dat), .all_i(all_f),
        .sclk_o(sclk), .mosi_o(mosi), .cs_n_o(cs_n), .done_o(done)
    );

    function automatic logic [7:0] ref_entry(input logic [7:0] n);
        logic [7:0] r = n;
        for (int k = 0; k < 8; k++) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h2F) : {r[6:0], 1'b0};
        return r;
    endfunction

    function automatic logic [31:0] ref_word(input logic [20:0] v);
        logic [4:0] rev;
        logic [23:0] x;
        logic [7:0] c;
        if (v[20]) return 32'hF800030A;
        for (int k = 0; k < 5; k++) rev[k] = v[19-k];
        x = {3'b000, rev, v[14:9], v[8:1], v[0], 1'b0};
        c = ref_entry(x[23:16]);
        c = ref_entry(c ^ x[15:8]);
        c = c ^ x[7:0];
        return {x[20:0], c, 3'b010};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_req(input logic [20:0] v);
        {dummy, idx, rg, dat, all_f} = v;
    endtask

    // Drives one start cycle at a negedge; returns at the following negedge.
    task automatic kick(input logic [20:0] v);
        set_req(v);
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    // Collects a word until done; optionally injects a stray request mid-word.
    task automatic collect(input logic inject, output logic [31:0] got,
                           output int low, output int rises, output int bad);
        logic ps = 0, pm, pcs = 0;
        got = 0; low = 0; rises = 0; bad = 0;
        pm = mosi;
        for (int it = 0; it < 20000; it++) begin
            if (!cs_n) low++;
            if (ps && !sclk) got = {got[30:0], mosi};
            if (!ps && sclk) rises++;
            if (!cs_n && pcs && (mosi != pm) && !(!ps && sclk)) bad++;
            if (done) return;
            ps = sclk; pm = mosi; pcs = !cs_n;
            if (inject && it == 20) begin
                set_req({1'b0, 5'd2, 6'h3E, 8'h0F, 1'b1});
                start = 1;
            end else start = 0;
            @(negedge clk);
        end
        fails++; checks++;
        $display("FAIL R8 actual=no done expected=done within limit");
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] got;
        int low, rises, bad;
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9 cs_n in reset", 32'(cs_n), 1);
        check("R9 sclk/mosi/done in reset", {29'b0, sclk, mosi, done}, 0);
        rst_n = 1;
        @(negedge clk);
        check("R9 rest after reset", {28'b0, cs_n, sclk, mosi, done}, 32'h8);

        for (int i = 0; i < NV; i++) begin
            kick(VEC[i]);
            collect(1'b0, got, low, rises, bad);
            check(VEC[i][20] ? "R4 filler word" : "R1/R2/R3 word", got, ref_word(VEC[i]));
            check("R6 cs low cycles", 32'(low), 32'(64*H));
            check("R5 rising edges", 32'(rises), 32);
            check("R5 mosi changes off rise", 32'(bad), 0);
            check("R8 done with cs high", {31'b0, cs_n}, 1);
            @(negedge clk);
            check("R8 done one cycle", {31'b0, done}, 0);
            repeat (3) @(negedge clk);
        end

        // R2 known answer: position 0x1F, all fields zero gives code 0x61
        kick({1'b0, 5'd31, 6'h00, 8'h00, 1'b0});
        collect(1'b0, got, low, rises, bad);
        check("R2 known code 0x61", 32'(got[10:3]), 32'h61);
        check("R4 normal request equals filler", got, 32'hF800030A);
        repeat (2) @(negedge clk);

        // R3 position 1 puts a one only in word bit 31 of the address
        kick({1'b0, 5'd1, 6'h00, 8'h00, 1'b0});
        collect(1'b0, got, low, rises, bad);
        check("R3 reversed position 1", 32'(got[31:27]), 32'h10);
        repeat (2) @(negedge clk);

        // R7 stray request mid-word is ignored
        kick({1'b0, 5'd4, 6'h17, 8'hC3, 1'b0});
        collect(1'b1, got, low, rises, bad);
        check("R7 word unchanged", got, ref_word({1'b0, 5'd4, 6'h17, 8'hC3, 1'b0}));
        start = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (cs_n !== 1'b1) begin
                check("R7 no extra word", {31'b0, cs_n}, 1);
                break;
            end
        end
        check("R7 idle after ignored start", {31'b0, cs_n}, 1);

        // R8 start in the done cycle is accepted at once
        kick({1'b0, 5'd5, 6'h09, 8'h66, 1'b1});
        collect(1'b0, got, low, rises, bad);
        check("R8 first word", got, ref_word({1'b0, 5'd5, 6'h09, 8'h66, 1'b1}));
        kick({1'b0, 5'd12, 6'h31, 8'h99, 1'b0});
        check("R8 cs low after done-cycle start", {31'b0, cs_n}, 0);
        check("R8 done cleared", {31'b0, done}, 0);
        collect(1'b0, got, low, rises, bad);
        check("R8 back-to-back word", got, ref_word({1'b0, 5'd12, 6'h31, 8'h99, 1'b0}));
        check("R6 back-to-back cs low cycles", 32'(low), 32'(64*H));

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule